// File: doc/BRIEF.md
# Machine Check Interrupt Controller

This block collects the machine-check conditions a processor core reports. There are five classes: system recovery (a retry that succeeded, or an intermittent single-bit error that was corrected), interval-timer damage, timing-facilities damage, system damage and instruction-processing damage. Each arriving condition sets a pending bit. A pending bit stays set until an interruption that reports it is acknowledged. A master enable and two sub-masks decide which pending classes are visible. When any visible class is pending, the block raises an interrupt request and presents a code word in which every visible pending class has a fixed bit.

Three classes are repressible: system recovery, interval-timer damage and timing-facilities damage. These need a sub-mask as well as the master enable. System damage and instruction-processing damage are exigent. They need only the master enable, and the code word flags them with a summary bit.

The block also counts consecutive microinstruction retries. It pulses an extended-logout request after the first retry and again after the eighth. The counter clears when the retry is reported as successful or as unretryable.

Top module: `mck_ctrl`

## Requirements
- R1: While `masterEn` is 0, `intReq` is 0 and `mcCode` is 0, whatever conditions are pending and whatever `maskR` and `maskE` are.
- R2: A pending system-recovery condition (`evtIn` bit 0, or `retryGood`) is reported only while both `masterEn` and `maskR` are 1. It is reported as `mcCode` bit 2.
- R3: Pending interval-timer damage (`evtIn` bit 1) and timing-facilities damage (`evtIn` bit 2) are reported only while both `masterEn` and `maskE` are 1. They appear as `mcCode` bits 3 and 4.
- R4: Pending system damage (`evtIn` bit 3) and instruction-processing damage (`evtIn` bit 4, or `retryFail`) are reported whenever `masterEn` is 1, independent of `maskR` and `maskE`. They appear as `mcCode` bits 0 and 1.
- R5: A condition that arrives while masked stays pending. It is reported, and `intReq` rises, as soon as its masks allow it. No new strobe is needed.
- R6: A clock edge with `intAck` high clears exactly the pending classes that are reported in that cycle. Masked pending classes survive the acknowledge.
- R7: `mcCode` reports every enabled pending class at once. Bit 7 is 1 when any exigent class is reported. All other bits are 0. `intReq` is 1 exactly when `mcCode` is nonzero.
- R8: `retryGood` sets system recovery pending and `retryFail` sets instruction-processing damage pending. Either one resets the retry count to zero, and it takes priority over a `retryStep` in the same cycle.
- R9: `logoutReq` is a one-cycle pulse in the cycle after the 1st and after the 8th consecutive `retryStep`. It is 0 after every other step.
- R10: The retry count saturates at 15, so steps beyond the 15th never produce a logout pulse until the count is reset.
- R11: A condition strobed on the same edge as an acknowledge that clears its class remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 5 | Condition strobes: bit0 recovery, bit1 interval timer, bit2 timing facilities, bit3 system damage, bit4 instruction damage |
| masterEn | input | 1 | Master machine-check enable |
| maskR | input | 1 | Recovery sub-mask |
| maskE | input | 1 | External (timer) sub-mask |
| intAck | input | 1 | Interruption taken; clears reported classes |
| retryStep | input | 1 | One microinstruction retry performed |
| retryGood | input | 1 | Retry succeeded |
| retryFail | input | 1 | Error is unretryable |
| intReq | output | 1 | Machine-check interruption request |
| mcCode | output | 8 | Machine-check code word |
| logoutReq | output | 1 | Extended-logout request pulse |

## Verification
The bench sweeps every combination of pending classes against all eight settings of the three mask bits. It checks the request and code word, then checks what survives an acknowledge. A design that let a sub-mask gate an exigent class, or cleared masked bits on acknowledge, fails that sweep. The retry tests step past the eighth and the sixteenth retry. A counter that wrapped instead of saturating would pulse logout again on the seventeenth step, and one that ignored a success or failure report would miss the next first-retry pulse. A separate case strobes a condition on the acknowledge edge, so a design that let the clear win would lose that event.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int NUM_CLS = 5;

  localparam int CLS_SR  = 0;
  localparam int CLS_ITD = 1;
  localparam int CLS_TFD = 2;
  localparam int CLS_SD  = 3;
  localparam int CLS_IPD = 4;

  localparam int CODE_EXIG = 7;

  typedef struct packed {
    logic [NUM_CLS-1:0] clrVec;
    logic               cntInc;
    logic               cntClr;
  } mck_strobe_t;

  function automatic bit isExigent(int cls);
    return (cls == CLS_SD) || (cls == CLS_IPD);
  endfunction

  function automatic int codePos(int cls);
    case (cls)
      CLS_SD:  return 0;
      CLS_IPD: return 1;
      CLS_SR:  return 2;
      CLS_ITD: return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/mck_ctl.sv
module mck_ctl
  import mck_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic               maskR,
  input  logic               maskE,
  input  logic               intAck,
  input  logic               retryStep,
  input  logic               retryGood,
  input  logic               retryFail,
  input  logic [NUM_CLS-1:0] pendVec,
  output logic [NUM_CLS-1:0] enVec,
  output logic               intReq,
  output mck_strobe_t        strobe
);

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_en
    if (isExigent(i)) begin : g_exig
      assign enVec[i] = masterEn;
    end else if (i == CLS_SR) begin : g_rec
      assign enVec[i] = masterEn & maskR;
    end else begin : g_ext
      assign enVec[i] = masterEn & maskE;
    end
  end

  logic [NUM_CLS-1:0] repVec;
  assign repVec = pendVec & enVec;
  assign intReq = |repVec;

  always_comb begin
    strobe        = '0;
    strobe.clrVec = intAck ? repVec : '0;
    strobe.cntClr = retryGood | retryFail;
    strobe.cntInc = retryStep & ~strobe.cntClr;
  end

  p_master_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> !intReq);

  p_exigent_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && (pendVec[CLS_SD] || pendVec[CLS_IPD])) |-> intReq);

endmodule

// File: rtl/mck_dp.sv
module mck_dp
  import mck_pkg::*;
#(
  parameter int RETRY_W    = 4,
  parameter int LOG_FIRST  = 1,
  parameter int LOG_SECOND = 8,
  parameter int CODE_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CLS-1:0] evtIn,
  input  logic               retryGood,
  input  logic               retryFail,
  input  logic [NUM_CLS-1:0] enVec,
  input  mck_strobe_t        strobe,
  output logic [NUM_CLS-1:0] pendVec,
  output logic [CODE_W-1:0]  mcCode,
  output logic               logoutReq
);

  localparam logic [RETRY_W-1:0] CNT_MAX = {RETRY_W{1'b1}};
  localparam logic [RETRY_W-1:0] HIT_A   = RETRY_W'(LOG_FIRST);
  localparam logic [RETRY_W-1:0] HIT_B   = RETRY_W'(LOG_SECOND);

  logic [NUM_CLS-1:0] setVec;
  logic [NUM_CLS-1:0] pendQ;
  logic [RETRY_W-1:0] cntQ;
  logic [RETRY_W-1:0] cntNext;
  logic               logoutQ;

  always_comb begin
    setVec          = evtIn;
    setVec[CLS_SR]  = evtIn[CLS_SR] | retryGood;
    setVec[CLS_IPD] = evtIn[CLS_IPD] | retryFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~strobe.clrVec) | setVec;
  end

  assign cntNext = cntQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      logoutQ <= 1'b0;
    end else begin
      logoutQ <= 1'b0;
      if (strobe.cntClr) begin
        cntQ <= '0;
      end else if (strobe.cntInc && cntQ != CNT_MAX) begin
        cntQ    <= cntNext;
        logoutQ <= (cntNext == HIT_A) || (cntNext == HIT_B);
      end
    end
  end

  logic [NUM_CLS-1:0] repVec;
  assign repVec = pendQ & enVec;

  always_comb begin
    mcCode = '0;
    for (int i = 0; i < NUM_CLS; i++) mcCode[codePos(i)] = repVec[i];
    mcCode[CODE_EXIG] = repVec[CLS_SD] | repVec[CLS_IPD];
  end

  assign pendVec   = pendQ;
  assign logoutReq = logoutQ;

  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ != '0) |=> ((($past(pendQ) & ~$past(strobe.clrVec)) & ~pendQ) == '0));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((($past(setVec)) & ~pendQ) == '0));

  p_logout_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    logoutReq |-> (cntQ == HIT_A || cntQ == HIT_B));

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == CNT_MAX && strobe.cntInc) |=> (cntQ == CNT_MAX));

  p_cnt_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cntQ == '0 && !logoutReq));

endmodule

// File: rtl/mck_ctrl.sv
module mck_ctrl
  import mck_pkg::*;
#(
  parameter int RETRY_W    = 4,
  parameter int LOG_FIRST  = 1,
  parameter int LOG_SECOND = 8,
  parameter int CODE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        evtIn,
  input  logic              masterEn,
  input  logic              maskR,
  input  logic              maskE,
  input  logic              intAck,
  input  logic              retryStep,
  input  logic              retryGood,
  input  logic              retryFail,
  output logic              intReq,
  output logic [CODE_W-1:0] mcCode,
  output logic              logoutReq
);

  logic [NUM_CLS-1:0] pendVec;
  logic [NUM_CLS-1:0] enVec;
  mck_strobe_t        strobe;

  mck_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .masterEn  (masterEn),
    .maskR     (maskR),
    .maskE     (maskE),
    .intAck    (intAck),
    .retryStep (retryStep),
    .retryGood (retryGood),
    .retryFail (retryFail),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .intReq    (intReq),
    .strobe    (strobe)
  );

  mck_dp #(
    .RETRY_W    (RETRY_W),
    .LOG_FIRST  (LOG_FIRST),
    .LOG_SECOND (LOG_SECOND),
    .CODE_W     (CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .retryGood (retryGood),
    .retryFail (retryFail),
    .enVec     (enVec),
    .strobe    (strobe),
    .pendVec   (pendVec),
    .mcCode    (mcCode),
    .logoutReq (logoutReq)
  );

  p_sr_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    mcCode[2] |-> (masterEn && maskR));

  p_ext_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mcCode[3] || mcCode[4]) |-> (masterEn && maskE));

  p_req_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    intReq == (mcCode != '0));

endmodule

// File: tb/mck_ctrl_bench.sv
module mck_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] evtIn = '0;
  logic       masterEn = 1'b0, maskR = 1'b0, maskE = 1'b0;
  logic       intAck = 1'b0, retryStep = 1'b0, retryGood = 1'b0, retryFail = 1'b0;
  logic       intReq, logoutReq;
  logic [7:0] mcCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mck_ctrl u_mck_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .masterEn(masterEn), .maskR(maskR),
    .maskE(maskE), .intAck(intAck), .retryStep(retryStep), .retryGood(retryGood),
    .retryFail(retryFail), .intReq(intReq), .mcCode(mcCode), .logoutReq(logoutReq)
  );

  function automatic logic [4:0] enOf(logic m, logic r, logic e);
    return m ? {1'b1, 1'b1, e, e, r} : 5'b0;
  endfunction

  function automatic logic [7:0] codeOf(logic [4:0] p);
    return {p[3] | p[4], 2'b00, p[2], p[1], p[0], p[4], p[3]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setMask(input logic m, input logic r, input logic e);
    masterEn = m; maskR = r; maskE = e;
  endtask

  task automatic inject(input logic [4:0] v);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic step();
    retryStep = 1'b1;
    @(negedge clk);
    retryStep = 1'b0;
  endtask

  task automatic clearAll();
    setMask(1, 1, 1);
    ack();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    setMask(1, 1, 1);
    #1;
    chk("R1 reset intReq", intReq, 0);
    chk("R7 reset code", mcCode, 0);
    chk("R9 reset logout", logoutReq, 0);
    @(negedge clk);

    // R1 and R5: masked by master enable, then presented once enabled
    setMask(0, 1, 1);
    inject(5'h1F);
    #1;
    chk("R1 master off intReq", intReq, 0);
    chk("R1 master off code", mcCode, 0);
    setMask(1, 1, 1);
    #1;
    chk("R5 presented after unmask", mcCode, 8'h9F);
    chk("R5 intReq after unmask", intReq, 1);
    @(negedge clk);
    clearAll();

    // R2
    setMask(1, 0, 1);
    inject(5'h01);
    #1;
    chk("R2 recovery masked by R", intReq, 0);
    maskR = 1'b1;
    #1;
    chk("R2 recovery code bit2", mcCode, 8'h04);
    @(negedge clk);
    clearAll();

    // R3
    setMask(1, 1, 0);
    inject(5'h06);
    #1;
    chk("R3 timers masked by E", intReq, 0);
    maskE = 1'b1;
    #1;
    chk("R3 timer code bits", mcCode, 8'h18);
    @(negedge clk);
    clearAll();

    // R4
    setMask(1, 0, 0);
    inject(5'h08);
    #1;
    chk("R4 system damage", mcCode, 8'h81);
    @(negedge clk);
    ack();
    inject(5'h10);
    #1;
    chk("R4 instr damage", mcCode, 8'h82);
    chk("R4 instr damage req", intReq, 1);
    @(negedge clk);
    clearAll();

    // R11: set on the clearing edge wins
    setMask(1, 1, 1);
    inject(5'h01);
    evtIn = 5'h01;
    ack();
    evtIn = '0;
    #1;
    chk("R11 set beats clear", mcCode, 8'h04);
    @(negedge clk);
    clearAll();

    // Sweep all pending patterns against all mask settings (R6, R7)
    for (int pat = 0; pat < 32; pat++) begin
      for (int msk = 0; msk < 8; msk++) begin
        logic [4:0] en;
        logic [4:0] p;
        p = 5'(pat);
        en = enOf(msk[2], msk[1], msk[0]);
        setMask(0, 0, 0);
        inject(p);
        setMask(msk[2], msk[1], msk[0]);
        #1;
        chk("R7 sweep code", mcCode, codeOf(p & en));
        chk("R7 sweep intReq", intReq, |(p & en));
        ack();
        setMask(1, 1, 1);
        #1;
        chk("R6 sweep survivors", mcCode, codeOf(p & ~en));
        ack();
        #1;
        chk("R6 sweep cleared", mcCode, 0);
      end
    end

    // R9 and R10: logout pulses over twenty consecutive retries
    setMask(1, 1, 1);
    for (int i = 1; i <= 20; i++) begin
      step();
      #1;
      chk($sformatf("R9 R10 logout after step %0d", i), logoutReq, (i == 1 || i == 8));
    end

    // R8: success clears count and sets recovery pending
    retryGood = 1'b1;
    @(negedge clk);
    retryGood = 1'b0;
    #1;
    chk("R8 retryGood sets recovery", mcCode, 8'h04);
    chk("R8 no logout on clear", logoutReq, 0);
    ack();
    step();
    #1;
    chk("R8 count reset by retryGood", logoutReq, 1);
    for (int i = 2; i <= 5; i++) step();

    // R8: failure with a simultaneous step, clear has priority
    retryFail = 1'b1;
    retryStep = 1'b1;
    @(negedge clk);
    retryFail = 1'b0;
    retryStep = 1'b0;
    #1;
    chk("R8 retryFail sets instr damage", mcCode, 8'h82);
    chk("R8 step ignored under clear", logoutReq, 0);
    ack();
    step();
    #1;
    chk("R8 count reset by retryFail", logoutReq, 1);
    step();
    #1;
    chk("R9 second step no logout", logoutReq, 0);

    summary();
  end
endmodule